// File: doc/BRIEF.md
# Masked Vector Unsigned-to-Single Converter

This block turns a vector of 32-bit unsigned integers into IEEE-754 single-precision values, one conversion per lane. Up to sixteen lanes are processed in parallel. A length code selects how many of them are active: 4, 8 or 16. Each active lane can be enabled or disabled by a write mask. A disabled lane either keeps the value from the old destination vector or is cleared, depending on the masking policy. Every lane above the active length is cleared.

A source flag marks the operand as coming from memory. With that flag and the shared override flag both set, the low element is replicated into every lane. For a register operand, the same override flag instead selects a per-operation rounding mode, but only at the full 512-bit length. In every other case the global rounding mode applies.

A request that carries a malformed specifier field, or an unsupported length code, raises a fault. Such a request writes nothing. Results, the fault flag and an accumulating inexact flag appear one clock after the request.

Top module: `uvc_vec_cvt`

## Requirements
- R1: An enabled lane outputs the correctly rounded single-precision value of its 32-bit unsigned source, and a zero source gives 32'h00000000.
- R2: The rounding code selects the mode: 2'b00 nearest-even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, 2'b11 toward zero.
- R3: When rounding overflows the 24-bit significand, the exponent is incremented. For example, 32'hFFFFFFFF under nearest-even gives 32'h4F800000.
- R4: Length code 2'b00, 2'b01 and 2'b10 activates 4, 8 and 16 lanes. Lane n occupies bits 32n+31:32n, and all result bits above the active lanes are zero.
- R5: With masking enabled and a lane's mask bit clear, that lane takes the old destination lane when zeroing is off.
- R6: With masking enabled, a clear mask bit and zeroing on, that lane is zero. With masking disabled, every active lane is converted regardless of mask bits.
- R7: The override rounding code is used only when the source is a register, the length code is 2'b10 and the override flag is set. Otherwise the global code is used.
- R8: With a memory source and the override flag set, bits 31:0 of the source are converted into every enabled active lane.
- R9: A request whose specifier is not 4'b1111, or whose length code is 2'b11, raises the fault output in the next cycle. It leaves out_valid low and keeps the result and the inexact flag unchanged.
- R10: The inexact flag is set by any enabled active lane that rounds, is never set by masked-off lanes, and stays set until reset.
- R11: out_valid is high exactly one cycle after each legal request. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Source integers, 16 lanes of 32 bits |
| old_vec | input | 512 | Prior destination used for merging |
| lane_mask | input | 16 | Per-lane write enable |
| mask_en | input | 1 | Apply lane_mask when high |
| zero_mode | input | 1 | 1 = clear masked lanes, 0 = merge |
| len_code | input | 2 | Active length select |
| mem_src | input | 1 | Source comes from memory |
| ovr_flag | input | 1 | Broadcast (memory) or rounding override (register) |
| ovr_rm | input | 2 | Per-operation rounding code |
| glob_rm | input | 2 | Global rounding code |
| spec_field | input | 4 | Unused specifier, must be 4'b1111 |
| out_valid | output | 1 | Result written this cycle |
| result | output | 512 | Converted vector |
| inexact | output | 1 | Accumulated precision flag |
| fault | output | 1 | Illegal-encoding fault |

## Verification
On every cycle, the assertions check the one-cycle valid timing, that a fault never coincides with a valid result and leaves the result and inexact flag untouched, that the inexact flag never drops, and that lanes above the active length read zero. Whether each rounded value is numerically right depends on the values involved. So do the choice between override and global rounding, broadcast, merge versus zero policy, and the exclusion of masked lanes from the inexact flag. Only the bench's scenarios show these, by comparing against its arithmetic model on every clock.

// File: rtl/uvc_pkg.sv
package uvc_pkg;
  localparam int LANE_W = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/uvc_lane_cvt.sv
module uvc_lane_cvt
  import uvc_pkg::*;
(
  input  logic [LANE_W-1:0] din,
  input  rmode_e            rm,
  output logic [LANE_W-1:0] dout,
  output logic              inexact
);
  logic [4:0]  msb;
  logic [31:0] norm;
  logic        guard, stk, up;
  logic [24:0] sum;
  logic [7:0]  expo;

  always_comb begin
    msb = '0;
    for (int i = 0; i < 32; i++) begin
      if (din[i]) msb = 5'(i);
    end
    norm    = din << (5'd31 - msb);
    guard   = norm[7];
    stk     = |norm[6:0];
    inexact = guard | stk;
    case (rm)
      RM_NEAR: up = guard & (stk | norm[8]);
      RM_UP:   up = inexact;
      default: up = 1'b0;
    endcase
    sum  = {1'b0, norm[31:8]} + 25'(up);
    expo = 8'd127 + {3'b000, msb} + {7'b0, sum[24]};
    if (din == '0) dout = '0;
    else           dout = {1'b0, expo, (sum[24] ? sum[23:1] : sum[22:0])};
  end
endmodule

// File: rtl/uvc_lane_pick.sv
module uvc_lane_pick
  import uvc_pkg::*;
(
  input  logic [LANE_W-1:0] conv,
  input  logic [LANE_W-1:0] old,
  input  logic              active,
  input  logic              wr_en,
  input  logic              zero_mode,
  output logic [LANE_W-1:0] lane_out
);
  always_comb begin
    if (!active)       lane_out = '0;
    else if (wr_en)    lane_out = conv;
    else if (zero_mode) lane_out = '0;
    else               lane_out = old;
  end
endmodule

// File: rtl/uvc_vec_cvt.sv
module uvc_vec_cvt
  import uvc_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MIN_LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] src_vec,
  input  logic [LANES*LANE_W-1:0] old_vec,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic [1:0]              len_code,
  input  logic                    mem_src,
  input  logic                    ovr_flag,
  input  logic [1:0]              ovr_rm,
  input  logic [1:0]              glob_rm,
  input  logic [3:0]              spec_field,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result,
  output logic                    inexact,
  output logic                    fault
);
  localparam int VW  = LANES * LANE_W;
  localparam int CW  = $clog2(LANES * 8) + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // request decode
  logic [CW-1:0] lanes_act;
  logic          len_ok, full_len, legal, bcast;
  rmode_e        rm_eff;

  always_comb begin
    lanes_act = CW'(MIN_LANES) << len_code;
    len_ok    = (len_code != 2'b11) && (lanes_act <= CW'(LANES));
    full_len  = (lanes_act == CW'(LANES));
    legal     = len_ok && (spec_field == SPEC_OK);
    bcast     = mem_src && ovr_flag;
    rm_eff    = (!mem_src && full_len && ovr_flag) ? rmode_e'(ovr_rm)
                                                   : rmode_e'(glob_rm);
  end

  // lane array
  logic [VW-1:0]    conv_vec;
  logic [LANES-1:0] lane_inx, lane_use;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] op, cv;
    logic              act, wen;
    assign op  = bcast ? src_vec[LANE_W-1:0] : src_vec[g*LANE_W +: LANE_W];
    assign act = (CW'(g) < lanes_act);
    assign wen = !mask_en || lane_mask[g];
    assign lane_use[g] = act && wen;

    uvc_lane_cvt u_cvt (
      .din     (op),
      .rm      (rm_eff),
      .dout    (cv),
      .inexact (lane_inx[g])
    );

    uvc_lane_pick u_pick (
      .conv      (cv),
      .old       (old_vec[g*LANE_W +: LANE_W]),
      .active    (act),
      .wr_en     (wen),
      .zero_mode (zero_mode),
      .lane_out  (conv_vec[g*LANE_W +: LANE_W])
    );
  end

  // next state
  logic          valid_d, fault_d, wr_en, sticky_d;
  logic          valid_q, fault_q, sticky_q;
  logic [VW-1:0] res_q;

  always_comb begin
    valid_d  = in_valid && legal;
    fault_d  = in_valid && !legal;
    wr_en    = in_valid && legal;
    sticky_d = sticky_q || (|(lane_inx & lane_use));
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      fault_q  <= 1'b0;
      sticky_q <= 1'b0;
      res_q    <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      if (wr_en) begin
        res_q    <= conv_vec;
        sticky_q <= sticky_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign fault     = fault_q;
  assign inexact   = sticky_q;
  assign result    = res_q;

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && legal) |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  // R9
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault |-> !out_valid);

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault |-> ($stable(result) && $stable(inexact)));

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    inexact |=> inexact);

  for (genvar g = 0; g < LANES; g++) begin : g_upper
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (out_valid && (CW'(g) >= (CW'(MIN_LANES) << $past(len_code))))
        |-> (result[g*LANE_W +: LANE_W] == '0));
  end
endmodule

// File: tb/uvc_vec_cvt_test.sv
module uvc_vec_cvt_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] src_vec, old_vec;
  logic [15:0]  lane_mask;
  logic         mask_en, zero_mode, mem_src, ovr_flag;
  logic [1:0]   len_code, ovr_rm, glob_rm;
  logic [3:0]   spec_field;
  logic         out_valid, inexact, fault;
  logic [511:0] result;

  int checks = 0;
  int fails  = 0;
  string scen = "R11";

  always #5 clk = ~clk;

  uvc_vec_cvt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .old_vec(old_vec), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .len_code(len_code), .mem_src(mem_src),
    .ovr_flag(ovr_flag), .ovr_rm(ovr_rm), .glob_rm(glob_rm),
    .spec_field(spec_field), .out_valid(out_valid), .result(result),
    .inexact(inexact), .fault(fault)
  );

  // arithmetic reference: quotient/remainder rounding, returns {inexact, bits}
  function automatic logic [32:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm);
    int msb, sh, e;
    longint q, rem, half;
    bit up;
    if (x == 0) return 33'd0;
    msb = 0;
    for (int b = 0; b < 32; b++) if (x[b]) msb = b;
    e = 127 + msb;
    sh = msb - 23;
    if (sh <= 0) begin
      q = longint'(x) << (-sh);
      rem = 0; half = 1;
    end else begin
      q = longint'(x) >> sh;
      rem = longint'(x) - (q << sh);
      half = longint'(1) << (sh - 1);
    end
    case (rm)
      2'b00: up = (rem > half) || (rem == half && q[0]);
      2'b10: up = (rem != 0);
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (q == (longint'(1) << 24)) begin q = q >> 1; e = e + 1; end
    return {rem != 0, 1'b0, 8'(e), 23'(q)};
  endfunction

  // model state, advanced on every clock
  logic         m_valid, m_fault, m_sticky;
  logic [511:0] m_res;
  string        m_tag = "R11";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_fault = 0; m_sticky = 0; m_res = '0;
    end else begin
      m_tag = scen;
      m_valid = 0; m_fault = 0;
      if (in_valid) begin
        if (spec_field != 4'hF || len_code == 2'b11) m_fault = 1;
        else begin
          int nl;
          logic [1:0] rm;
          nl = 4 << len_code;
          rm = (!mem_src && len_code == 2'b10 && ovr_flag) ? ovr_rm : glob_rm;
          m_valid = 1;
          for (int j = 0; j < 16; j++) begin
            logic [32:0] r;
            logic [31:0] s;
            s = (mem_src && ovr_flag) ? src_vec[31:0] : src_vec[j*32 +: 32];
            r = ref_cvt(s, rm);
            if (j >= nl) m_res[j*32 +: 32] = 0;
            else if (!mask_en || lane_mask[j]) begin
              m_res[j*32 +: 32] = r[31:0];
              if (r[32]) m_sticky = 1;
            end else if (zero_mode) m_res[j*32 +: 32] = 0;
            else m_res[j*32 +: 32] = old_vec[j*32 +: 32];
          end
        end
      end
    end
  end

  task automatic cmp(string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", m_tag, what, act, exp);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("out_valid", 512'(out_valid), 512'(m_valid));
      cmp("fault",     512'(fault),     512'(m_fault));
      cmp("inexact",   512'(inexact),   512'(m_sticky));
      cmp("result",    result,          m_res);
    end
  end

  function automatic logic [511:0] mkvec(int seed);
    logic [511:0] v;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] h;
      h = 32'(seed) * 32'h9E3779B9 ^ (32'(i) * 32'h85EBCA6B);
      h = h ^ (h >> 13);
      h = h * 32'hC2B2AE35;
      v[i*32 +: 32] = h >> ((i * 3 + seed) % 29);
    end
    return v;
  endfunction

  task automatic op(string tag, logic [511:0] s, logic [1:0] len, logic men,
                    logic [15:0] msk, logic zm, logic mem, logic flg,
                    logic [1:0] orm, logic [1:0] grm, logic [3:0] spec);
    scen = tag;
    src_vec = s; old_vec = mkvec(777); len_code = len; mask_en = men;
    lane_mask = msk; zero_mode = zm; mem_src = mem; ovr_flag = flg;
    ovr_rm = orm; glob_rm = grm; spec_field = spec; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [511:0] fill(logic [31:0] a, logic [31:0] b);
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = i[0] ? b : a;
    return v;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    src_vec = '0; old_vec = '0; lane_mask = '0; mask_en = 0; zero_mode = 0;
    len_code = 2'b10; mem_src = 0; ovr_flag = 0; ovr_rm = 0; glob_rm = 0;
    spec_field = 4'hF;
    do_reset();
    scen = "R11";
    @(negedge clk);

    // R10: exact lanes only, inexact value sits in a masked-off lane
    begin
      logic [511:0] v;
      for (int i = 0; i < 16; i++) v[i*32 +: 32] = 32'(i * 1000);
      v[2*32 +: 32] = 32'h01000001;
      op("R10", v, 2'b10, 1, 16'hFFFB, 0, 0, 0, 0, 2'b10, 4'hF);
      op("R10", v, 2'b10, 1, 16'hFFFF, 0, 0, 0, 0, 2'b10, 4'hF);
      op("R10", mkvec(0), 2'b00, 0, 16'h0, 0, 0, 0, 0, 0, 4'hF);
    end

    // R1: assorted magnitudes, nearest-even, full length
    for (int k = 1; k < 6; k++) op("R1", mkvec(k), 2'b10, 0, 16'h0, 0, 0, 0, 0, 0, 4'hF);
    op("R1", '0, 2'b10, 0, 16'h0, 0, 0, 0, 0, 0, 4'hF);

    // R2: ties and near-ties under every mode
    for (int m = 0; m < 4; m++) begin
      op("R2", fill(32'h01000001, 32'h01000003), 2'b10, 0, 0, 0, 0, 0, 0, 2'(m), 4'hF);
      op("R2", mkvec(40 + m), 2'b10, 0, 0, 0, 0, 0, 0, 2'(m), 4'hF);
    end

    // R3: carry out of the significand
    op("R3", fill(32'hFFFFFFFF, 32'hFFFFFF80), 2'b10, 0, 0, 0, 0, 0, 0, 2'b00, 4'hF);
    op("R3", fill(32'hFFFFFFFF, 32'h00FFFFFF), 2'b10, 0, 0, 0, 0, 0, 0, 2'b10, 4'hF);

    // R4: shorter lengths clear upper lanes
    op("R4", mkvec(9), 2'b00, 0, 0, 0, 0, 0, 0, 0, 4'hF);
    op("R4", mkvec(10), 2'b01, 0, 0, 0, 0, 0, 0, 0, 4'hF);

    // R5 merge, R6 zeroing and mask ignored when disabled
    op("R5", mkvec(11), 2'b10, 1, 16'hA5C3, 0, 0, 0, 0, 0, 4'hF);
    op("R5", mkvec(12), 2'b01, 1, 16'h0F0F, 0, 0, 0, 0, 0, 4'hF);
    op("R6", mkvec(13), 2'b10, 1, 16'h3C96, 1, 0, 0, 0, 0, 4'hF);
    op("R6", mkvec(14), 2'b10, 0, 16'h0000, 1, 0, 0, 0, 0, 4'hF);

    // R7: override only for register source at full length
    op("R7", mkvec(15), 2'b10, 0, 0, 0, 0, 1, 2'b10, 2'b11, 4'hF);
    op("R7", mkvec(16), 2'b01, 0, 0, 0, 0, 1, 2'b10, 2'b11, 4'hF);
    op("R7", mkvec(17), 2'b10, 0, 0, 0, 1, 0, 2'b10, 2'b11, 4'hF);

    // R8: broadcast of element 0
    op("R8", mkvec(18), 2'b10, 0, 0, 0, 1, 1, 2'b10, 2'b01, 4'hF);
    op("R8", mkvec(19), 2'b01, 1, 16'h00C5, 1, 1, 1, 0, 2'b00, 4'hF);

    // R9: faults hold state
    op("R9", mkvec(20), 2'b10, 0, 0, 0, 0, 0, 0, 0, 4'hE);
    op("R9", mkvec(21), 2'b11, 0, 0, 0, 0, 0, 0, 0, 4'hF);

    // R11: back-to-back requests
    scen = "R11";
    src_vec = mkvec(22); len_code = 2'b10; mask_en = 0; mem_src = 0;
    ovr_flag = 0; spec_field = 4'hF; in_valid = 1;
    @(negedge clk);
    src_vec = mkvec(23);
    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule